// File: doc/BRIEF.md
# Two-Stage Serial Clock Prescaler

This block derives the bit timing of a two-wire serial engine from the system clock. The divider has three stages in a chain. A fixed divider of 2·(THP+1) system cycles produces a reference tick. A power-of-two stage then divides that tick by 2^N to give the sampling rate. A linear stage divides by (M+1) to give the phase tick. Ten phase ticks make one serial clock period.

The engine's shifting logic uses the outputs to time its work. The phase tick strobe comes with the index of the phase that begins. A serial clock level is derived from the phase. Two strobes mark the moment to drive a new data bit and the moment to sample the data line. A 7-bit control value holds M and N. It is captured from a write port, but it is applied only when a serial clock period ends, so every period runs with one consistent divider.

Top module: `sclk_prescaler`

## Requirements
- R1: The reference stage emits one tick every 2·(THP+1) system clock cycles, where THP is a build parameter.
- R2: The sampling stage emits one tick every 2^N reference ticks, where N is the 3-bit field in bits 2:0 of the control value.
- R3: A phase tick (`tick_o` high for one cycle) occurs every 2·(THP+1)·2^N·(M+1) system clock cycles, where M is the 4-bit field in bits 6:3 of the control value.
- R4: The control value is a byte whose bit 7 is absent. M occupies bits 6:3 and N occupies bits 2:0. Writing 7'h11, for example, selects M=2 and N=1.
- R5: `phase_o` steps by one at every phase tick, through 0,1,…,9 and then back to 0, so there are ten ticks per serial clock period. It does not change between ticks.
- R6: `scl_o` is low while `phase_o` is 0 to 4 and high while it is 5 to 9.
- R7: `sda_chg_o` pulses together with the tick that starts phase 2. `sda_smp_o` pulses together with the tick that starts phase 7. Neither pulses at any other time.
- R8: A value written with `cfg_wr_i` takes effect at the first phase tick after the write that wraps `phase_o` from 9 to 0. If several writes arrive before that tick, the last one applies.
- R9: While `rst_i` is high (synchronous, active high), all counters clear, `phase_o` is 0, and no strobe is issued. Both the pending and the active control values return to CFG_RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Capture `cfg_i` as the pending control value |
| cfg_i | input | 7 | Control value: M in bits 6:3, N in bits 2:0 |
| tick_o | output | 1 | One-cycle pulse at the start of each phase |
| phase_o | output | 4 | Index of the current phase, 0 to 9 |
| scl_o | output | 1 | Serial clock level derived from the phase |
| sda_chg_o | output | 1 | Strobe that marks the point to drive a data bit (phase 2) |
| sda_smp_o | output | 1 | Strobe that marks the point to sample the data line (phase 7) |

## Verification
Any wrong count in one of the three counters moves the next `tick_o` pulse away from its expected cycle. A per-cycle comparison against a behavioural timing model therefore catches the fault within one tick interval. A wrong phase register, or a control value applied too early, shows up at the latest within one serial clock period. It appears as a misplaced `phase_o`, `scl_o` or data strobe, or as a tick spacing that changes in mid-period. Scenarios with large N and with M=15 exercise the upper bits of the counters and the control fields.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    // control value: M in the upper four bits, N in the lower three
    typedef struct packed {
        logic [3:0] m;
        logic [2:0] n;
    } sclk_cfg_t;

    localparam int NUM_PHASES   = 10;
    localparam int PHASE_W      = 4;
    localparam int POW_W        = 7;
    localparam int SCL_HI_PHASE = 5;
    localparam int SDA_CHG_PH   = 2;
    localparam int SDA_SMP_PH   = 7;

    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_PHASES - 1);

    function automatic logic [POW_W-1:0] pow2_last(input logic [2:0] n);
        return POW_W'((1 << n) - 1);
    endfunction

    function automatic logic [PHASE_W-1:0] phase_step(input logic [PHASE_W-1:0] p);
        return (p == LAST_PHASE) ? '0 : p + PHASE_W'(1);
    endfunction

endpackage

// File: rtl/sclk_ref_div.sv
module sclk_ref_div #(
    parameter int THP = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic ref_tick_o
);
    localparam int REF_DIV = 2 * (THP + 1);
    localparam int CNT_W   = $clog2(REF_DIV);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= '0;
        else if (cnt_q == CNT_LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign ref_tick_o = (cnt_q == CNT_LAST) && !rst_i;

    // R1
    ref_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ref_tick_o |=> !ref_tick_o);

endmodule

// File: rtl/sclk_pow2_stage.sv
module sclk_pow2_stage
    import sclk_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ref_tick_i,
    input  logic [2:0] n_i,
    output logic       samp_tick_o
);
    logic [POW_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == pow2_last(n_i));

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= '0;
        else if (ref_tick_i)
            cnt_q <= at_last ? '0 : cnt_q + POW_W'(1);
    end

    assign samp_tick_o = ref_tick_i && at_last;

    // R2
    samp_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        samp_tick_o |=> !samp_tick_o);

endmodule

// File: rtl/sclk_phase_stage.sv
module sclk_phase_stage
    import sclk_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               samp_tick_i,
    input  logic [3:0]         m_i,
    output logic               wrap_o,
    output logic               tick_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               scl_o,
    output logic               sda_chg_o,
    output logic               sda_smp_o
);
    logic [3:0]         lin_q;
    logic [PHASE_W-1:0] phase_q;
    logic               tick_q;
    logic               adv;

    assign adv    = samp_tick_i && (lin_q == m_i);
    assign wrap_o = adv && (phase_q == LAST_PHASE);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lin_q   <= '0;
            phase_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= adv;
            if (samp_tick_i)
                lin_q <= (lin_q == m_i) ? '0 : lin_q + 4'd1;
            if (adv)
                phase_q <= phase_step(phase_q);
        end
    end

    assign tick_o    = tick_q;
    assign phase_o   = phase_q;
    assign scl_o     = (phase_q >= PHASE_W'(SCL_HI_PHASE));
    assign sda_chg_o = tick_q && (phase_q == PHASE_W'(SDA_CHG_PH));
    assign sda_smp_o = tick_q && (phase_q == PHASE_W'(SDA_SMP_PH));

    // R5
    phase_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_q <= LAST_PHASE);

    // R7
    sda_strobe_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({sda_chg_o, sda_smp_o}));

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
    import sclk_pkg::*;
#(
    parameter int         THP       = 3,
    parameter logic [6:0] CFG_RESET = 7'h00
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       cfg_wr_i,
    input  logic [6:0] cfg_i,
    output logic       tick_o,
    output logic [3:0] phase_o,
    output logic       scl_o,
    output logic       sda_chg_o,
    output logic       sda_smp_o
);
    sclk_cfg_t pend_q;
    sclk_cfg_t act_q;
    logic      ref_tick;
    logic      samp_tick;
    logic      wrap;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= sclk_cfg_t'(CFG_RESET);
            act_q  <= sclk_cfg_t'(CFG_RESET);
        end else begin
            if (wrap)
                act_q <= pend_q;
            if (cfg_wr_i)
                pend_q <= sclk_cfg_t'(cfg_i);
        end
    end

    sclk_ref_div #(.THP(THP)) u_ref (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ref_tick_o (ref_tick)
    );

    sclk_pow2_stage u_pow (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .ref_tick_i  (ref_tick),
        .n_i         (act_q.n),
        .samp_tick_o (samp_tick)
    );

    sclk_phase_stage u_phase (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .samp_tick_i (samp_tick),
        .m_i         (act_q.m),
        .wrap_o      (wrap),
        .tick_o      (tick_o),
        .phase_o     (phase_o),
        .scl_o       (scl_o),
        .sda_chg_o   (sda_chg_o),
        .sda_smp_o   (sda_smp_o)
    );

    // R8
    cfg_at_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(act_q) |-> (phase_o == 4'd0));

    // R3
    tick_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> !tick_o);

    // R9
    reset_quiet_chk: assert property (@(posedge clk_i)
        rst_i |=> (!tick_o && !sda_chg_o && !sda_smp_o && phase_o == 4'd0));

endmodule

// File: tb/test_sclk_prescaler.sv
module test_sclk_prescaler;

    localparam int THP     = 1;
    localparam int REF_DIV = 2 * (THP + 1);
    localparam int WDOG    = 150000;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       cfg_wr_i = 1'b0;
    logic [6:0] cfg_i = '0;
    logic       tick_o, scl_o, sda_chg_o, sda_smp_o;
    logic [3:0] phase_o;

    always #10 clk = ~clk;

    sclk_prescaler #(.THP(THP), .CFG_RESET(7'h00)) i_sclk_prescaler (
        .clk_i     (clk),
        .rst_i     (rst_i),
        .cfg_wr_i  (cfg_wr_i),
        .cfg_i     (cfg_i),
        .tick_o    (tick_o),
        .phase_o   (phase_o),
        .scl_o     (scl_o),
        .sda_chg_o (sda_chg_o),
        .sda_smp_o (sda_smp_o)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;
    string cur_req = "R9";

    // behavioural timing model
    int m_cnt = 0;
    int m_phase = 0;
    int m_act = 0;
    int m_pend = 0;
    bit m_tick = 0;

    function automatic int interval(input int cfg);
        return REF_DIV * (1 << (cfg & 7)) * (((cfg >> 3) & 15) + 1);
    endfunction

    task automatic check1(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     cur_req, what, act, exp, cycles);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        cycles++;
        if (rst_i) begin
            m_cnt = 0; m_phase = 0; m_act = 0; m_pend = 0; m_tick = 0;
        end else begin
            m_cnt++;
            m_tick = 0;
            if (m_cnt == interval(m_act)) begin
                m_cnt = 0;
                m_phase = (m_phase + 1) % 10;
                m_tick = 1;
                if (m_phase == 0) m_act = m_pend;
            end
            if (cfg_wr_i) m_pend = cfg_i;
        end
        @(negedge clk);
        check1("tick_o (R3)", tick_o, m_tick);
        check1("phase_o (R5)", phase_o, m_phase);
        check1("scl_o (R6)", scl_o, m_phase >= 5);
        check1("sda_chg_o (R7)", sda_chg_o, m_tick && m_phase == 2);
        check1("sda_smp_o (R7)", sda_smp_o, m_tick && m_phase == 7);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [6:0] v);
        cfg_wr_i = 1'b1;
        cfg_i = v;
        cyc();
        cfg_wr_i = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R9";
        run(4);
        rst_i = 1'b0;
        cur_req = "R1";             // M=0,N=0: tick every REF_DIV cycles
        run(100);
        cur_req = "R4";             // 7'h11 -> M=2, N=1
        wr(7'h11);
        run(500);
        cur_req = "R2";             // N=3, M=0
        wr(7'h03);
        run(700);
        cur_req = "R8";             // two writes in one period: last wins
        wr(7'h7F);
        run(5);
        wr(7'h08);
        run(600);
        cur_req = "R3";             // M=15, N=0
        wr(7'h78);
        run(1500);
        cur_req = "R9";             // reset in mid-period, held a few cycles
        run(37);
        rst_i = 1'b1;
        run(3);
        rst_i = 1'b0;
        run(100);
        cur_req = "R2";             // largest N
        wr(7'h07);
        run(6000);
        cur_req = "R6";
        wr(7'h01);
        run(400);
        done = 1;
        summary();
    end

    initial begin
        for (int i = 0; i < WDOG; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule